// File: doc/BRIEF.md
# Process-Tagged Translation Buffer

This block translates 32-bit virtual addresses into physical addresses. It holds a small fully associative table, 64 slots by default, and compares every slot at once. A mapped address splits into a 20-bit virtual page number and a 12-bit offset. The page number is matched against the table together with a 6-bit process identifier, and the matching slot's frame number replaces it. The offset is carried across unchanged. A slot marked global matches any process identifier. A fixed decode of the top address bits sends some kernel regions around the table: one is cached and unmapped, one is uncached and unmapped. The rest of the kernel half and the whole user half go through the table.

Management software never reaches the table directly. It stages a slot image in two staging registers: a tag register for the page number and process id, and a data register for the frame number and flags. It then commits the image to the slot named by a software-loaded index register, or to the slot named by a free-running random counter. It can also read a slot back into the staging registers, or probe the table for the tag currently staged. The tag register also supplies the process id for every lookup. A lookup is answered one cycle after it is requested. The answer is one of four outcomes: hit, miss, modify (a store to a page that is not writable), or multiple match. Refilling the table from page tables in memory is left to software.

Top module: `tlb_mmu`

## Requirements
- R1: After reset, all four software-visible registers read as zero except the random counter, which reads ENTRIES-1 (63). Every slot is empty, so a lookup in a mapped region reports miss.
- R2: The random counter steps down by one on every clock. From WIRED (8) it wraps to ENTRIES-1 (63), so it never shows a value below 8.
- R3: The command codes are on cmdOp with cmdValid high. Code 1 loads the tag register, with page number from cmdData[31:12] and process id from cmdData[5:0]. Code 2 loads the data register, with frame number from cmdData[31:12] and flags from cmdData[3:0] (bit 3 no-cache, bit 2 writable, bit 1 valid, bit 0 global). Code 3 loads the index field from cmdData[5:0] and clears the probe-fail bit 31. All other bits of these registers read back as zero.
- R4: Code 5 writes the staged tag and data into the slot named by the index field. Code 4 copies the slot named by the index field back into the tag and data registers.
- R5: Code 6 writes the staged tag and data into the slot whose number the random counter shows during the cycle of the command.
- R6: A lookup request in a mapped region that matches exactly one valid slot reports hit on the next cycle. The physical address is the slot's frame number followed by the unchanged offset. Cached is the inverse of the slot's no-cache flag.
- R7: A slot matches only if it is valid, its page number is equal, and either it is global or its process id equals the tag register's process id. A mapped lookup with no matching slot reports miss with physical address zero.
- R8: A store lookup (lkWrite high) that matches a single slot whose writable flag is clear reports modify rather than hit or miss. A store to a writable slot reports hit.
- R9: A mapped lookup that matches two or more slots reports multiple match, with hit, miss and modify low and physical address zero.
- R10: The region is decoded from the top address bits. Addresses with bit 31 clear are mapped. 3'b100 in bits 31:29 is unmapped and cached. 3'b101 is unmapped and uncached. 2'b11 in bits 31:30 is mapped. An unmapped lookup reports hit with rspMapped low and a physical address equal to the low 29 address bits.
- R11: Code 7 searches for the staged tag. On a match the index field takes the lowest matching slot and bit 31 is cleared. With no match, bit 31 is set and the index field becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Management command strobe |
| cmdOp | input | 3 | Management command code |
| cmdData | input | 32 | Operand for register loads |
| entryHi | output | 32 | Tag staging register |
| entryLo | output | 32 | Data staging register |
| indexReg | output | 32 | Index field with probe-fail bit 31 |
| randomReg | output | 6 | Random replacement counter |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Virtual address to translate |
| lkWrite | input | 1 | Lookup is a store |
| rspValid | output | 1 | Response present, one cycle after request |
| rspPhysAddr | output | 32 | Translated physical address |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No slot matched |
| rspModify | output | 1 | Store to a non-writable page |
| rspMulti | output | 1 | Two or more slots matched |
| rspMapped | output | 1 | Address went through the table |
| rspCached | output | 1 | Access may be cached |

## Verification
The hardest outcomes to reach are the multiple-match case and a random-slot write that lands in a known slot. The management path normally keeps slots distinct, and the random counter moves on every clock. The bench installs two identical tags through indexed writes to reach the duplicate case. It then confirms that the probe picks the lower slot. For the random write, the bench samples the counter output in the same cycle that it issues the command. It then reads that slot back through the index register to prove where the write landed. Every one of the 64 slots is also filled with an arithmetically derived image and swept for hit, foreign-process, store and probe behaviour.

// File: rtl/tlb_mmu_pkg.sv
package tlb_mmu_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_SET_HI     = 3'd1,
    OP_SET_LO     = 3'd2,
    OP_SET_IDX    = 3'd3,
    OP_READ       = 3'd4,
    OP_WRITE_IDX  = 3'd5,
    OP_WRITE_RAND = 3'd6,
    OP_PROBE      = 3'd7
  } tlbOp_e;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic loadIdx;
    logic readEntry;
    logic writeEntry;
    logic probe;
  } tlbStrobe_t;

  localparam int FLAG_W     = 4;
  localparam int FL_NOCACHE = 3;
  localparam int FL_DIRTY   = 2;
  localparam int FL_VALID   = 1;
  localparam int FL_GLOBAL  = 0;

endpackage

// File: rtl/tlb_mmu_ctrl.sv
module tlb_mmu_ctrl
  import tlb_mmu_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [IDX_W-1:0] idxField,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] wrSlot,
  output logic [IDX_W-1:0] randomVal
);

  localparam logic [IDX_W-1:0] RND_TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] RND_LOW = IDX_W'(WIRED);

  tlbOp_e op;
  logic [IDX_W-1:0] rnd;

  assign op = tlbOp_e'(cmdOp);

  // free-running replacement counter, never enters the wired slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rnd <= RND_TOP;
    end else if (rnd == RND_LOW) begin
      rnd <= RND_TOP;
    end else begin
      rnd <= rnd - 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      case (op)
        OP_SET_HI:     strobe.loadHi     = 1'b1;
        OP_SET_LO:     strobe.loadLo     = 1'b1;
        OP_SET_IDX:    strobe.loadIdx    = 1'b1;
        OP_READ:       strobe.readEntry  = 1'b1;
        OP_WRITE_IDX:  strobe.writeEntry = 1'b1;
        OP_WRITE_RAND: strobe.writeEntry = 1'b1;
        OP_PROBE:      strobe.probe      = 1'b1;
        default:       strobe = '0;
      endcase
    end
  end

  assign wrSlot    = (op == OP_WRITE_RAND) ? rnd : idxField;
  assign randomVal = rnd;

  // R2: counter stays above the wired slots
  a_r2_random_floor: assert property (@(posedge clk) disable iff (!rstN)
    rnd >= RND_LOW);

  // R2: wrap from the floor back to the top
  a_r2_random_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rnd == RND_LOW) |=> (rnd == RND_TOP));

  // R5: a random write never targets a wired slot
  a_r5_rand_slot: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && op == OP_WRITE_RAND) |-> (wrSlot >= RND_LOW));

endmodule

// File: rtl/tlb_mmu_datapath.sv
module tlb_mmu_datapath
  import tlb_mmu_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int PID_W    = 6,
  parameter int VPN_W    = 20,
  parameter int OFF_W    = 12,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ADDR_W  = VPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrSlot,
  input  logic [ADDR_W-1:0] cmdData,
  output logic [IDX_W-1:0]  idxField,
  output logic [ADDR_W-1:0] entryHi,
  output logic [ADDR_W-1:0] entryLo,
  output logic [ADDR_W-1:0] indexReg,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspModify,
  output logic              rspMulti,
  output logic              rspMapped,
  output logic              rspCached
);

  localparam int UNMAP_W = ADDR_W - 3;

  // slot storage
  logic [VPN_W-1:0]  eVpn   [ENTRIES];
  logic [PID_W-1:0]  ePid   [ENTRIES];
  logic [VPN_W-1:0]  ePfn   [ENTRIES];
  logic [FLAG_W-1:0] eFlags [ENTRIES];

  // software-visible staging state
  logic [VPN_W-1:0]  hiVpn;
  logic [PID_W-1:0]  hiPid;
  logic [VPN_W-1:0]  loPfn;
  logic [FLAG_W-1:0] loFlags;
  logic [IDX_W-1:0]  idxVal;
  logic              idxFail;

  logic [ENTRIES-1:0] lkHit;
  logic [ENTRIES-1:0] prHit;
  logic [VPN_W-1:0]   lkVpn;

  assign lkVpn = lkAddr[ADDR_W-1:OFF_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lkHit[e] = eFlags[e][FL_VALID] && (eVpn[e] == lkVpn) &&
                      (eFlags[e][FL_GLOBAL] || (ePid[e] == hiPid));
    assign prHit[e] = eFlags[e][FL_VALID] && (eVpn[e] == hiVpn) &&
                      (eFlags[e][FL_GLOBAL] || (ePid[e] == hiPid));
  end

  // lookup reduction: single, multiple, selected image
  logic              lkAny;
  logic              lkMany;
  logic [VPN_W-1:0]  selPfn;
  logic [FLAG_W-1:0] selFlags;

  always_comb begin
    lkAny    = 1'b0;
    lkMany   = 1'b0;
    selPfn   = '0;
    selFlags = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lkHit[e]) begin
        if (lkAny) lkMany = 1'b1;
        lkAny    = 1'b1;
        selPfn   = selPfn | ePfn[e];
        selFlags = selFlags | eFlags[e];
      end
    end
  end

  // probe: lowest matching slot wins
  logic             prFound;
  logic [IDX_W-1:0] prIdx;

  always_comb begin
    prFound = 1'b0;
    prIdx   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (prHit[e] && !prFound) begin
        prFound = 1'b1;
        prIdx   = IDX_W'(e);
      end
    end
  end

  // slot array update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        eVpn[e]   <= '0;
        ePid[e]   <= '0;
        ePfn[e]   <= '0;
        eFlags[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strobe.writeEntry && (wrSlot == IDX_W'(e))) begin
          eVpn[e]   <= hiVpn;
          ePid[e]   <= hiPid;
          ePfn[e]   <= loPfn;
          eFlags[e] <= loFlags;
        end
      end
    end
  end

  // staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiVpn   <= '0;
      hiPid   <= '0;
      loPfn   <= '0;
      loFlags <= '0;
      idxVal  <= '0;
      idxFail <= 1'b0;
    end else begin
      if (strobe.loadHi) begin
        hiVpn <= cmdData[ADDR_W-1:OFF_W];
        hiPid <= cmdData[PID_W-1:0];
      end
      if (strobe.loadLo) begin
        loPfn   <= cmdData[ADDR_W-1:OFF_W];
        loFlags <= cmdData[FLAG_W-1:0];
      end
      if (strobe.loadIdx) begin
        idxVal  <= cmdData[IDX_W-1:0];
        idxFail <= 1'b0;
      end
      if (strobe.readEntry) begin
        hiVpn   <= eVpn[idxVal];
        hiPid   <= ePid[idxVal];
        loPfn   <= ePfn[idxVal];
        loFlags <= eFlags[idxVal];
      end
      if (strobe.probe) begin
        idxFail <= !prFound;
        idxVal  <= prFound ? prIdx : '0;
      end
    end
  end

  assign idxField = idxVal;
  assign entryHi  = {hiVpn, {(OFF_W - PID_W){1'b0}}, hiPid};
  assign entryLo  = {loPfn, {(OFF_W - FLAG_W){1'b0}}, loFlags};
  assign indexReg = {idxFail, {(ADDR_W - 1 - IDX_W){1'b0}}, idxVal};

  // region decode and next response
  logic [2:0]        topBits;
  logic              isMapped;
  logic              nHit, nMiss, nModify, nMulti, nCached;
  logic [ADDR_W-1:0] nPhys;

  assign topBits  = lkAddr[ADDR_W-1 -: 3];
  assign isMapped = !((topBits == 3'b100) || (topBits == 3'b101));

  always_comb begin
    nHit    = 1'b0;
    nMiss   = 1'b0;
    nModify = 1'b0;
    nMulti  = 1'b0;
    nCached = 1'b0;
    nPhys   = '0;
    if (!isMapped) begin
      nHit    = 1'b1;
      nCached = (topBits == 3'b100);
      nPhys   = {3'b000, lkAddr[UNMAP_W-1:0]};
    end else if (lkMany) begin
      nMulti = 1'b1;
    end else if (!lkAny) begin
      nMiss = 1'b1;
    end else if (lkWrite && !selFlags[FL_DIRTY]) begin
      nModify = 1'b1;
    end else begin
      nHit    = 1'b1;
      nCached = !selFlags[FL_NOCACHE];
      nPhys   = {selPfn, lkAddr[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspMiss     <= 1'b0;
      rspModify   <= 1'b0;
      rspMulti    <= 1'b0;
      rspMapped   <= 1'b0;
      rspCached   <= 1'b0;
      rspPhysAddr <= '0;
    end else begin
      rspValid    <= lkValid;
      rspHit      <= lkValid && nHit;
      rspMiss     <= lkValid && nMiss;
      rspModify   <= lkValid && nModify;
      rspMulti    <= lkValid && nMulti;
      rspMapped   <= lkValid && isMapped;
      rspCached   <= lkValid && nCached;
      rspPhysAddr <= lkValid ? nPhys : '0;
    end
  end

  // R6: a request is answered on the following cycle
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  // R9: each response carries exactly one outcome
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspHit, rspMiss, rspModify, rspMulti}) == 1));

  // R7: no outcome without a response
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspModify || rspMulti));

  // R8: modify only follows a store request
  a_r8_modify_store: assert property (@(posedge clk) disable iff (!rstN)
    rspModify |-> $past(lkWrite));

  // R10: unmapped hits land in the low physical window
  a_r10_unmapped_low: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && !rspMapped) |-> (rspPhysAddr[ADDR_W-1 -: 3] == 3'b000));

endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
  import tlb_mmu_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  parameter int PID_W   = 6,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = VPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdData,
  output logic [ADDR_W-1:0] entryHi,
  output logic [ADDR_W-1:0] entryLo,
  output logic [ADDR_W-1:0] indexReg,
  output logic [IDX_W-1:0]  randomReg,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspModify,
  output logic              rspMulti,
  output logic              rspMapped,
  output logic              rspCached
);

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] wrSlot;
  logic [IDX_W-1:0] idxField;

  tlb_mmu_ctrl #(
    .ENTRIES (ENTRIES),
    .WIRED   (WIRED)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .idxField  (idxField),
    .strobe    (strobe),
    .wrSlot    (wrSlot),
    .randomVal (randomReg)
  );

  tlb_mmu_datapath #(
    .ENTRIES (ENTRIES),
    .PID_W   (PID_W),
    .VPN_W   (VPN_W),
    .OFF_W   (OFF_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrSlot      (wrSlot),
    .cmdData     (cmdData),
    .idxField    (idxField),
    .entryHi     (entryHi),
    .entryLo     (entryLo),
    .indexReg    (indexReg),
    .lkValid     (lkValid),
    .lkAddr      (lkAddr),
    .lkWrite     (lkWrite),
    .rspValid    (rspValid),
    .rspPhysAddr (rspPhysAddr),
    .rspHit      (rspHit),
    .rspMiss     (rspMiss),
    .rspModify   (rspModify),
    .rspMulti    (rspMulti),
    .rspMapped   (rspMapped),
    .rspCached   (rspCached)
  );

endmodule

// File: tb/tb_tlb_mmu.sv
`timescale 1ns/1ps
module tb_tlb_mmu;

  localparam logic [2:0] C_SET_HI = 3'd1, C_SET_LO = 3'd2, C_SET_IDX = 3'd3,
                         C_READ = 3'd4, C_WR_IDX = 3'd5, C_WR_RAND = 3'd6,
                         C_PROBE = 3'd7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [31:0] cmdData = '0;
  logic [31:0] entryHi, entryLo, indexReg;
  logic [5:0] randomReg;
  logic lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic lkWrite = 1'b0;
  logic rspValid, rspHit, rspMiss, rspModify, rspMulti, rspMapped, rspCached;
  logic [31:0] rspPhysAddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tlb_mmu dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .entryHi(entryHi), .entryLo(entryLo), .indexReg(indexReg), .randomReg(randomReg),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite), .rspValid(rspValid),
    .rspPhysAddr(rspPhysAddr), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspModify(rspModify), .rspMulti(rspMulti), .rspMapped(rspMapped),
    .rspCached(rspCached)
  );

  // arithmetic slot images
  function automatic logic [19:0] vpnOf(int i); return 20'(i * 37 + 5); endfunction
  function automatic logic [5:0]  pidOf(int i); return 6'(i ^ 21); endfunction
  function automatic logic [19:0] pfnOf(int i); return 20'h A0000 + 20'(i * 3); endfunction
  function automatic logic isGlob(int i);  return (i % 8) == 7; endfunction
  function automatic logic isDirty(int i); return (i % 2) == 1; endfunction
  function automatic logic isNc(int i);    return (i % 5) == 0; endfunction
  function automatic logic [31:0] hiWord(int i);
    return {vpnOf(i), 6'b0, pidOf(i)};
  endfunction
  function automatic logic [31:0] loWord(int i);
    return {pfnOf(i), 8'b0, isNc(i), isDirty(i), 1'b1, isGlob(i)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags order: valid hit miss modify multi mapped cached
  task automatic checkRsp(input string req, input logic [5:0] expF, input logic [31:0] expPhys);
    check(req, {25'b0, rspValid, rspHit, rspMiss, rspModify, rspMulti, rspMapped, rspCached},
          {25'b0, 1'b1, expF});
    check(req, rspPhysAddr, expPhys);
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [31:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; cmdData = '0;
  endtask

  task automatic doLookup(input logic [31:0] a, input logic wr);
    lkValid = 1'b1; lkAddr = a; lkWrite = wr;
    @(posedge clk); @(negedge clk);
    lkValid = 1'b0; lkWrite = 1'b0;
  endtask

  task automatic installAt(input int slot, input logic [31:0] hi, input logic [31:0] lo);
    doCmd(C_SET_HI, hi);
    doCmd(C_SET_LO, lo);
    doCmd(C_SET_IDX, 32'(slot));
    doCmd(C_WR_IDX, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] off;
    logic [5:0] r;
    logic [5:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 entryHi", entryHi, 32'h0);
    check("R1 entryLo", entryLo, 32'h0);
    check("R1 index", indexReg, 32'h0);
    check("R1 random", {26'b0, randomReg}, 32'd63);
    rstN = 1'b1;
    doLookup(32'h0000_1000, 1'b0);
    checkRsp("R1 empty miss", 6'b010010, 32'h0);

    // R2 random sweep
    for (int k = 0; k < 150; k++) begin
      prev = randomReg;
      @(negedge clk);
      check("R2 step", {26'b0, randomReg}, (prev == 6'd8) ? 32'd63 : 32'(prev - 6'd1));
      checks++;
      if (randomReg < 6'd8) begin
        errors++;
        $display("FAIL R2 floor actual=%0d expected>=8", randomReg);
      end
    end

    // R3 field masking
    doCmd(C_SET_HI, 32'hFFFF_FFFF);
    check("R3 hi mask", entryHi, 32'hFFFF_F03F);
    doCmd(C_SET_LO, 32'hFFFF_FFFF);
    check("R3 lo mask", entryLo, 32'hFFFF_F00F);
    doCmd(C_SET_IDX, 32'hFFFF_FFFF);
    check("R3 idx mask", indexReg, 32'h0000_003F);

    // fill every slot
    for (int i = 0; i < 64; i++) installAt(i, hiWord(i), loWord(i));

    // R6 R7 R8 sweep
    for (int i = 0; i < 64; i++) begin
      off = 32'((i * 61 + 7) % 4096);
      doCmd(C_SET_HI, {26'b0, pidOf(i)});
      doLookup({vpnOf(i), off[11:0]}, 1'b0);
      checkRsp("R6 hit", {1'b1, 3'b000, 1'b1, !isNc(i)}, {pfnOf(i), off[11:0]});
      doLookup({vpnOf(i), off[11:0]}, 1'b1);
      if (isDirty(i)) checkRsp("R8 store hit", {1'b1, 3'b000, 1'b1, !isNc(i)}, {pfnOf(i), off[11:0]});
      else checkRsp("R8 modify", 6'b001010, 32'h0);
      doCmd(C_SET_HI, {26'b0, pidOf(i) + 6'd1});
      doLookup({vpnOf(i), off[11:0]}, 1'b0);
      if (isGlob(i)) checkRsp("R7 global", {1'b1, 3'b000, 1'b1, !isNc(i)}, {pfnOf(i), off[11:0]});
      else checkRsp("R7 pid miss", 6'b010010, 32'h0);
    end

    // R4 readback and R11 probe
    for (int i = 0; i < 64; i++) begin
      doCmd(C_SET_IDX, 32'(i));
      doCmd(C_READ, 32'h0);
      check("R4 read hi", entryHi, hiWord(i));
      check("R4 read lo", entryLo, loWord(i));
      doCmd(C_SET_HI, hiWord(i));
      doCmd(C_PROBE, 32'h0);
      check("R11 probe hit", indexReg, 32'(i));
    end
    doCmd(C_SET_HI, 32'h7FFF_F000);
    doCmd(C_PROBE, 32'h0);
    check("R11 probe miss", indexReg, 32'h8000_0000);
    doCmd(C_SET_IDX, 32'd4);
    check("R3 idx clears fail", indexReg, 32'd4);

    // R7 invalid slot never matches
    installAt(5, hiWord(5), loWord(5) & ~32'h2);
    doCmd(C_SET_HI, {26'b0, pidOf(5)});
    doLookup({vpnOf(5), 12'h010}, 1'b0);
    checkRsp("R7 invalid", 6'b010010, 32'h0);

    // R10 regions
    doLookup(32'h8012_3456, 1'b0);
    checkRsp("R10 kseg cached", 6'b100001, 32'h0012_3456);
    doLookup(32'hA0AB_CDEF, 1'b1);
    checkRsp("R10 kseg uncached", 6'b100000, 32'h00AB_CDEF);
    installAt(2, 32'hC000_1000, 32'h1234_500F);
    doLookup(32'hC000_1ABC, 1'b1);
    checkRsp("R10 kernel mapped", 6'b100010, 32'h1234_5ABC);
    doLookup(32'hE000_0000, 1'b0);
    checkRsp("R10 kernel miss", 6'b010010, 32'h0);

    // R9 duplicate slots
    installAt(0, 32'h4000_0009, 32'h3333_3006);
    installAt(1, 32'h4000_0009, 32'h4444_4006);
    doLookup(32'h4000_0010, 1'b0);
    checkRsp("R9 multi", 6'b000110, 32'h0);
    doCmd(C_PROBE, 32'h0);
    check("R11 lowest match", indexReg, 32'h0);

    // R5 random writes
    for (int k = 0; k < 3; k++) begin
      doCmd(C_SET_HI, {20'h12340 + 20'(k), 6'b0, 6'd3});
      doCmd(C_SET_LO, {20'h55550 + 20'(k), 12'h006});
      repeat (k + 1) @(negedge clk);
      r = randomReg;
      doCmd(C_WR_RAND, 32'h0);
      doCmd(C_SET_IDX, {26'b0, r});
      doCmd(C_READ, 32'h0);
      check("R5 rand hi", entryHi, {20'h12340 + 20'(k), 6'b0, 6'd3});
      check("R5 rand lo", entryLo, {20'h55550 + 20'(k), 12'h006});
      doLookup({20'h12340 + 20'(k), 12'h0AA}, 1'b1);
      checkRsp("R5 rand lookup", 6'b100011, {20'h55550 + 20'(k), 12'h0AA});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule